// File: doc/BRIEF.md
# Host Port-Mapped Memory Access Controller

This block is a byte-wide I/O slave that a host processor reaches through four consecutive port offsets. Behind those ports it keeps a control register, whose bits steer a target processor (write protection, halt, two interrupt lines and memory ownership), and a 16-bit address counter. The host reaches a shared memory only indirectly. It loads the counter one byte at a time, then reads or writes the data port. Each data-port access becomes one registered memory cycle at the counter address, and the counter then advances.

The counter post-increments after every granted data access. Setting the inhibit bit freezes the counter, so the host can poll or rewrite the same location, for example as a handshake mailbox. Host writes are sampled on a one-cycle write enable. Read data comes back registered, so it is valid from the second clock edge after the request and holds until the next read.

Top module: `pmem_host_ctrl`

## Requirements
- R1: After reset the control register and the address counter are zero, both memory strobes are low, and the host read data is 0x00.
- R2: Port offset 0 is the control register, and all eight bits read back as written. Bit 0 drives the target write-disable output, bit 1 inhibits the address increment, bit 2 drives target halt, bit 3 drives target IRQ, bit 4 drives target NMI, and bit 7 grants memory ownership to the host. Bits 5 and 6 are storage only.
- R3: A write to offset 2 loads the low byte of the counter, and a write to offset 3 loads the high byte. A read of either offset returns the matching counter byte.
- R4: A granted write to offset 1 raises the memory write strobe for exactly the cycle after the request edge. During that cycle the memory address equals the counter value before the request and the memory write data equals the host byte.
- R5: A granted read of offset 1 raises the memory read strobe for the cycle after the request edge, with the memory address equal to the counter value before the request. The memory data sampled at the end of that cycle is the host read data from the second edge after the request.
- R6: After each granted data access the counter increases by one, unless control bit 1 is set, in which case it keeps its value.
- R7: The increment carries from the low byte into the high byte, and 0xFFFF wraps to 0x0000.
- R8: While control bit 7 is clear, a data-port access is ignored: no memory strobe fires, the counter keeps its value, and a read returns 0xFF.
- R9: When host write and host read are asserted in the same cycle, only the write takes place.
- R10: The memory read strobe and the memory write strobe are never high in the same cycle.
- R11: Register reads (offsets 0, 2 and 3) follow the same timing as data reads: the value present at the request edge appears on the host read data from the second edge after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr_i | input | 2 | Port offset |
| host_wr_i | input | 1 | One-cycle host write enable |
| host_rd_i | input | 1 | One-cycle host read request |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Registered host read byte |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Memory read data, valid while the read strobe is high |
| tgt_wr_dis_o | output | 1 | Target write-disable |
| tgt_halt_o | output | 1 | Target halt |
| tgt_irq_o | output | 1 | Target interrupt request |
| tgt_nmi_o | output | 1 | Target non-maskable interrupt |
| host_owns_o | output | 1 | Host owns the memory |

## Verification
A counter that is off by one, or that carries wrongly, shows on the memory address during the very next data strobe. It also shows on the next address-port readback, two edges after that request. A wrong control bit appears on its target output in the cycle after the write. If the ownership gate is wrong, a strobe fires while ownership is clear, or a data read returns something other than 0xFF two edges after the request. A misrouted read source corrupts the host read data at that same point.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2 * DATA_W;

    typedef enum logic [1:0] {
        PORT_CTRL = 2'd0,
        PORT_DATA = 2'd1,
        PORT_ALO  = 2'd2,
        PORT_AHI  = 2'd3
    } port_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_REG  = 2'd1,
        SRC_MEM  = 2'd2,
        SRC_DENY = 2'd3
    } rsrc_e;

    typedef struct packed {
        logic own;
        logic spare6;
        logic spare5;
        logic nmi;
        logic irq;
        logic halt;
        logic inh;
        logic wr_dis;
    } ctrl_t;
endpackage

// File: rtl/pmem_port_decode.sv
module pmem_port_decode
    import pmem_pkg::*;
(
    input  logic [1:0] host_addr_i,
    input  logic       host_wr_i,
    input  logic       host_rd_i,
    input  logic       own_i,
    output logic       ctrl_we_o,
    output logic [1:0] ld_o,
    output logic       data_wr_o,
    output rsrc_e      rd_src_o
);
    port_e port;
    logic  rd_eff;

    always_comb begin
        port      = port_e'(host_addr_i);
        rd_eff    = host_rd_i && !host_wr_i;
        ctrl_we_o = host_wr_i && (port == PORT_CTRL);
        ld_o[0]   = host_wr_i && (port == PORT_ALO);
        ld_o[1]   = host_wr_i && (port == PORT_AHI);
        data_wr_o = host_wr_i && (port == PORT_DATA) && own_i;
        rd_src_o  = SRC_NONE;
        if (rd_eff) begin
            if (port != PORT_DATA) rd_src_o = SRC_REG;
            else if (own_i)        rd_src_o = SRC_MEM;
            else                   rd_src_o = SRC_DENY;
        end
    end
endmodule

// File: rtl/pmem_addr_counter.sv
module pmem_addr_counter #(
    parameter int HALF_W = 8,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ld_i,
    input  logic [HALF_W-1:0] ld_byte_i,
    input  logic              inc_i,
    output logic [CNT_W-1:0]  cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc_i) st_d.cnt = st_q.cnt + 1'b1;
        for (int h = 0; h < 2; h++) begin
            if (ld_i[h]) st_d.cnt[h*HALF_W +: HALF_W] = ld_byte_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R7
    wrap_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && ld_i == 2'b00) |=> ((st_q.cnt - $past(st_q.cnt)) == CNT_W'(1)));

    // R6
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && ld_i == 2'b00) |=> $stable(st_q.cnt));
endmodule

// File: rtl/pmem_access_seq.sv
module pmem_access_seq
    import pmem_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_go_i,
    input  rsrc_e         rd_src_i,
    input  logic [DW-1:0] reg_val_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          mem_we_o,
    output logic          mem_re_o,
    output logic [DW-1:0] host_rdata_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          we;
        logic          re;
        rsrc_e         src;
        logic [DW-1:0] snap;
        logic [DW-1:0] rdata;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;
        st_d.re  = 1'b0;
        st_d.src = rd_src_i;
        if (wr_go_i) begin
            st_d.we    = 1'b1;
            st_d.addr  = addr_i;
            st_d.wdata = wdata_i;
        end
        if (rd_src_i == SRC_MEM) begin
            st_d.re   = 1'b1;
            st_d.addr = addr_i;
        end
        if (rd_src_i == SRC_REG) st_d.snap = reg_val_i;
        case (st_q.src)
            SRC_MEM:  st_d.rdata = mem_rdata_i;
            SRC_REG:  st_d.rdata = st_q.snap;
            SRC_DENY: st_d.rdata = '1;
            default:  st_d.rdata = st_q.rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.src <= SRC_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr_o   = st_q.addr;
    assign mem_wdata_o  = st_q.wdata;
    assign mem_we_o     = st_q.we;
    assign mem_re_o     = st_q.re;
    assign host_rdata_o = st_q.rdata;

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    // R8
    deny_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.src == SRC_DENY) |=> (host_rdata_o == '1));
endmodule

// File: rtl/pmem_host_ctrl.sv
module pmem_host_ctrl
    import pmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_addr_i,
    input  logic              host_wr_i,
    input  logic              host_rd_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              tgt_wr_dis_o,
    output logic              tgt_halt_o,
    output logic              tgt_irq_o,
    output logic              tgt_nmi_o,
    output logic              host_owns_o
);
    ctrl_t             ctrl_d, ctrl_q;
    logic              ctrl_we;
    logic [1:0]        ld;
    logic              data_wr;
    rsrc_e             rd_src;
    logic              inc;
    logic [ADDR_W-1:0] cnt_w;
    logic [DATA_W-1:0] reg_val;

    pmem_port_decode u_dec (
        .host_addr_i (host_addr_i),
        .host_wr_i   (host_wr_i),
        .host_rd_i   (host_rd_i),
        .own_i       (ctrl_q.own),
        .ctrl_we_o   (ctrl_we),
        .ld_o        (ld),
        .data_wr_o   (data_wr),
        .rd_src_o    (rd_src)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) ctrl_d = ctrl_t'(host_wdata_i);
        inc = (data_wr || rd_src == SRC_MEM) && !ctrl_q.inh;
        case (port_e'(host_addr_i))
            PORT_ALO: reg_val = cnt_w[DATA_W-1:0];
            PORT_AHI: reg_val = cnt_w[ADDR_W-1:DATA_W];
            default:  reg_val = ctrl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    pmem_addr_counter #(.HALF_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_i      (ld),
        .ld_byte_i (host_wdata_i),
        .inc_i     (inc),
        .cnt_o     (cnt_w)
    );

    pmem_access_seq #(.DW(DATA_W), .AW(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_go_i      (data_wr),
        .rd_src_i     (rd_src),
        .reg_val_i    (reg_val),
        .addr_i       (cnt_w),
        .wdata_i      (host_wdata_i),
        .mem_rdata_i  (mem_rdata_i),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_we_o     (mem_we_o),
        .mem_re_o     (mem_re_o),
        .host_rdata_o (host_rdata_o)
    );

    assign tgt_wr_dis_o = ctrl_q.wr_dis;
    assign tgt_halt_o   = ctrl_q.halt;
    assign tgt_irq_o    = ctrl_q.irq;
    assign tgt_nmi_o    = ctrl_q.nmi;
    assign host_owns_o  = ctrl_q.own;

    // R8
    own_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) |-> $past(ctrl_q.own));

    // R6
    post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) |->
            ((cnt_w - mem_addr_o) == ($past(ctrl_q.inh) ? 16'd0 : 16'd1)));
endmodule

// File: tb/pmem_host_ctrl_tb.sv
`timescale 1ns/1ps
module pmem_host_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re;
    logic [7:0]  mem_rdata;
    logic        t_wd, t_halt, t_irq, t_nmi, t_own;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    logic [7:0]  ctrl_m = 8'd0;
    logic [15:0] cnt_m = 16'd0;

    always #4 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    assign mem_rdata = memf(mem_addr);

    pmem_host_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_addr_i(host_addr), .host_wr_i(host_wr), .host_rd_i(host_rd),
        .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata),
        .tgt_wr_dis_o(t_wd), .tgt_halt_o(t_halt), .tgt_irq_o(t_irq),
        .tgt_nmi_o(t_nmi), .host_owns_o(t_own)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // one host access; called at a negedge, returns at a negedge two cycles later
    task automatic acc(input logic w, input logic r, input logic [1:0] p, input logic [7:0] d);
        logic        own, ewe, ere, is_rd;
        logic [15:0] eaddr;
        logic [7:0]  erd;
        own   = ctrl_m[7];
        ewe   = w && p == 2'd1 && own;
        ere   = !w && r && p == 2'd1 && own;
        is_rd = r && !w;
        eaddr = cnt_m;
        case (p)
            2'd0: erd = ctrl_m;
            2'd1: erd = own ? memf(cnt_m) : 8'hFF;
            2'd2: erd = cnt_m[7:0];
            default: erd = cnt_m[15:8];
        endcase
        if (w) begin
            case (p)
                2'd0: ctrl_m = d;
                2'd2: cnt_m[7:0] = d;
                2'd3: cnt_m[15:8] = d;
                default: ;
            endcase
        end
        if ((ewe || ere) && !ctrl_m[1]) cnt_m = cnt_m + 16'd1;
        host_addr = p; host_wr = w; host_rd = r; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        chk("R4 we", {15'd0, mem_we}, {15'd0, ewe});
        chk("R5 re", {15'd0, mem_re}, {15'd0, ere});
        chk("R10 excl", {15'd0, mem_we & mem_re}, 16'd0);
        if (ewe) begin
            chk("R4 addr", mem_addr, eaddr);
            chk("R4 wdata", {8'd0, mem_wdata}, {8'd0, d});
        end
        if (ere) chk("R5 addr", mem_addr, eaddr);
        chk("R2 outs", {11'd0, t_own, t_nmi, t_irq, t_halt, t_wd},
            {11'd0, ctrl_m[7], ctrl_m[4], ctrl_m[3], ctrl_m[2], ctrl_m[0]});
        @(negedge clk);
        if (is_rd) chk((p == 2'd1) ? "R5 rdata" : "R11 rdata", {8'd0, host_rdata}, {8'd0, erd});
    endtask

    task automatic rd_cnt(input string tag);
        logic [15:0] e;
        e = cnt_m;
        acc(1'b0, 1'b1, 2'd2, 8'd0);
        chk(tag, {8'd0, host_rdata}, {8'd0, e[7:0]});
        acc(1'b0, 1'b1, 2'd3, 8'd0);
        chk(tag, {8'd0, host_rdata}, {8'd0, e[15:8]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 strobes", {14'd0, mem_we, mem_re}, 16'd0);
        chk("R1 rdata", {8'd0, host_rdata}, 16'd0);
        chk("R1 outs", {11'd0, t_own, t_nmi, t_irq, t_halt, t_wd}, 16'd0);
        rd_cnt("R1 cnt");
        acc(1'b0, 1'b1, 2'd0, 8'd0);
        chk("R1 ctrl", {8'd0, host_rdata}, 16'd0);

        // R8: no ownership, data accesses ignored
        acc(1'b1, 1'b0, 2'd1, 8'h3C);
        acc(1'b0, 1'b1, 2'd1, 8'd0);
        chk("R8 deny", {8'd0, host_rdata}, 16'h00FF);
        rd_cnt("R8 cnt");

        // R2: every control bit
        for (int b = 0; b < 8; b++) begin
            acc(1'b1, 1'b0, 2'd0, 8'(1 << b));
            acc(1'b0, 1'b1, 2'd0, 8'd0);
        end
        acc(1'b1, 1'b0, 2'd0, 8'hE0);

        // R3 and R7: carry and wrap
        acc(1'b1, 1'b0, 2'd2, 8'hFF);
        acc(1'b1, 1'b0, 2'd3, 8'h00);
        acc(1'b1, 1'b0, 2'd1, 8'h11);
        rd_cnt("R7 carry");
        chk("R7 carry val", cnt_m, 16'h0100);
        acc(1'b1, 1'b0, 2'd2, 8'hFF);
        acc(1'b1, 1'b0, 2'd3, 8'hFF);
        acc(1'b0, 1'b1, 2'd1, 8'd0);
        rd_cnt("R7 wrap");
        chk("R7 wrap val", cnt_m, 16'h0000);

        // R6: inhibit holds the counter
        acc(1'b1, 1'b0, 2'd0, 8'h82);
        acc(1'b1, 1'b0, 2'd1, 8'h5A);
        acc(1'b0, 1'b1, 2'd1, 8'd0);
        rd_cnt("R6 hold");
        acc(1'b1, 1'b0, 2'd0, 8'h80);

        // R9: write wins over read
        acc(1'b1, 1'b1, 2'd1, 8'h77);
        acc(1'b1, 1'b1, 2'd2, 8'h40);
        rd_cnt("R9 cnt");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [1:0] p;
            logic [7:0] d;
            int k;
            p = 2'($urandom);
            d = 8'($urandom);
            k = int'($urandom % 20);
            if (p == 2'd0 && ($urandom % 5) != 0) d[7] = 1'b1;
            if (k < 10)      acc(1'b1, 1'b0, p, d);
            else if (k < 19) acc(1'b0, 1'b1, p, d);
            else             acc(1'b1, 1'b1, p, d);
        end
        rd_cnt("R3 final");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule